// File: doc/BRIEF.md
# Serial ADC Command Interface Slave

This block is the digital serial front end of an eight-channel converter. It runs as an SPI mode-0 slave: chip select is active low, the serial clock idles low, input data is taken on rising edges and output data changes on falling edges. The three serial pins are brought into the system clock domain and their edges are detected there, so the whole block runs from one synchronous clock.

After chip select falls, the block looks for the first 1 on the data input. That bit opens an 8-bit control word. When the word is complete, its fields are decoded and presented for one system-clock cycle: channel number, polarity, single-ended or differential input, and power/clock mode. In external-clock mode the block then waits for the acquisition clocks and pulses a ready strobe for one serial period. It then shifts out a 12-bit result, MSB first, which it takes from a parallel port driven by a stand-in converter. In any other mode it goes straight back to looking for a start bit. Raising chip select ends any transaction at once.

Top module: `serial_adc_slave`

## Requirements
- R1: Data-in is sampled only on rising serial-clock edges while chip select is low. `dout` and `strobe` change only after falling serial-clock edges, so both hold steady across every high phase of the serial clock.
- R2: While looking for a start bit, 0 bits are discarded. The first 1 is the control word's bit 7, and the seven bits after it fill bits 6 down to 0.
- R3: Control word fields: bits 6:4 give the channel; bit 3 = 1 selects unipolar; bit 2 = 1 selects single-ended; bits 1:0 give the mode (00 full power-down, 01 fast power-down, 10 internal clock, 11 external clock). `ctl_valid` pulses for exactly one system clock when the eighth bit is taken. The field outputs are valid in that cycle and hold their value until the next control word.
- R4: In external-clock mode, `strobe` goes high after the second falling edge that follows the word's eighth rising edge. It stays high for exactly one serial period.
- R5: On the falling edge that ends the strobe, `dout` presents result bit 11. Each following falling edge presents the next lower bit, down to bit 0. The `result` port is latched when the strobe rises.
- R6: After bit 0 has been shown for one serial period, `dout` is low until chip select rises.
- R7: Chip select high aborts any transaction. Within a few system clocks `dout` and `strobe` are low, and a partly received control word is discarded. The next low phase of chip select starts a fresh start-bit search. After reset, `dout`, `strobe`, `dout_oe` and `ctl_valid` are low.
- R8: In any mode other than external clock, the block produces no strobe and no result bits and looks for a new start bit at once. A second control word in the same chip-select frame is accepted.
- R9: `dout_oe` is high while chip select is low and low while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, idles low |
| din | input | 1 | Serial command input |
| result | input | RES_W | Parallel conversion value from the converter model |
| dout | output | 1 | Serial result output |
| dout_oe | output | 1 | Output enable for `dout` |
| strobe | output | 1 | Ready strobe before the result MSB |
| ctl_valid | output | 1 | One-cycle pulse when a control word is complete |
| ctl_chan | output | 3 | Decoded channel number |
| ctl_unipolar | output | 1 | 1 = unipolar conversion |
| ctl_single | output | 1 | 1 = single-ended input |
| ctl_pmode | output | 2 | Power/clock mode field |

## Verification
The assertions check the following on every cycle:
- `dout` and `strobe` stay still except after a detected falling edge.
- The strobe lasts no more than one serial period, and `dout` is low while the strobe is high.
- Both outputs clear once chip select is high.
- The decode pulse follows a rising edge and never lasts two cycles.

Only the bench's frames can show the following:
- The exact serial position of the strobe and of each result bit for every channel, input-mode and leading-zero combination.
- That non-external modes stay silent.
- That a second word in one frame is accepted.
- That a partial word is discarded after an abort.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    localparam int CMD_W = 8;

    typedef enum logic [1:0] {
        PM_FULL_PD = 2'b00,
        PM_FAST_PD = 2'b01,
        PM_INT_CLK = 2'b10,
        PM_EXT_CLK = 2'b11
    } pmode_e;

    typedef struct packed {
        logic [2:0] chan;
        logic       unipolar;
        logic       single;
        pmode_e     pmode;
    } ctl_t;

    typedef enum logic {
        CMD_HUNT,
        CMD_SHIFT
    } cmd_st_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_WAIT,
        TX_DATA,
        TX_TAIL
    } tx_st_e;

    // Split the seven bits that follow the start bit into fields.
    function automatic ctl_t decode_ctl(input logic [CMD_W-2:0] b);
        ctl_t c;
        c.chan     = b[6:4];
        c.unipolar = b[3];
        c.single   = b[2];
        c.pmode    = pmode_e'(b[1:0]);
        return c;
    endfunction

endpackage

// File: rtl/sadc_front.sv
// Brings the serial pins into the clk domain and finds serial clock edges.
module sadc_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sclk,
    input  logic din,
    output logic cs_n_s,
    output logic din_s,
    output logic rise,
    output logic fall
);
    logic [SYNC_STAGES-1:0] cs_pipe, sclk_pipe, din_pipe;
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_pipe   <= '1;
            sclk_pipe <= '0;
            din_pipe  <= '0;
            sclk_q    <= 1'b0;
        end else begin
            cs_pipe[0]   <= cs_n;
            sclk_pipe[0] <= sclk;
            din_pipe[0]  <= din;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                cs_pipe[i]   <= cs_pipe[i-1];
                sclk_pipe[i] <= sclk_pipe[i-1];
                din_pipe[i]  <= din_pipe[i-1];
            end
            sclk_q <= sclk_pipe[SYNC_STAGES-1];
        end
    end

    assign cs_n_s = cs_pipe[SYNC_STAGES-1];
    assign din_s  = din_pipe[SYNC_STAGES-1];
    assign rise   = sclk_pipe[SYNC_STAGES-1] & ~sclk_q & ~cs_n_s;
    assign fall   = ~sclk_pipe[SYNC_STAGES-1] & sclk_q & ~cs_n_s;

endmodule

// File: rtl/sadc_cmd.sv
// Start-bit search and control word capture.
module sadc_cmd
    import sadc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs_n_s,
    input  logic rise,
    input  logic din_s,
    output logic ctl_valid,
    output ctl_t ctl
);
    localparam int CNT_W = $clog2(CMD_W);

    cmd_st_e          st;
    logic [CMD_W-2:0] sreg;
    logic [CNT_W-1:0] bcnt;
    logic [CMD_W-2:0] nxt;

    assign nxt = {sreg[CMD_W-3:0], din_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= CMD_HUNT;
            sreg      <= '0;
            bcnt      <= '0;
            ctl_valid <= 1'b0;
            ctl       <= '0;
        end else begin
            ctl_valid <= 1'b0;
            if (cs_n_s) begin
                st   <= CMD_HUNT;
                bcnt <= '0;
            end else if (rise) begin
                case (st)
                    CMD_HUNT: begin
                        if (din_s) begin
                            st   <= CMD_SHIFT;
                            bcnt <= CNT_W'(1);
                            sreg <= '0;
                        end
                    end
                    CMD_SHIFT: begin
                        sreg <= nxt;
                        if (bcnt == CNT_W'(CMD_W - 1)) begin
                            st        <= CMD_HUNT;
                            ctl_valid <= 1'b1;
                            ctl       <= decode_ctl(nxt);
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                    default: st <= CMD_HUNT;
                endcase
            end
        end
    end

    // R3: the decode pulse follows a sampled rising edge inside a frame
    a_r3_valid_after_rise: assert property (@(posedge clk) disable iff (rst)
        ctl_valid |-> ($past(rise) && !$past(cs_n_s)));

    // R3: the decode pulse lasts one cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        ctl_valid |=> !ctl_valid);

    // R2: a zero taken while searching leaves the search running
    a_r2_zero_ignored: assert property (@(posedge clk) disable iff (rst)
        (st == CMD_HUNT && rise && !din_s && !cs_n_s) |=> (st == CMD_HUNT));

endmodule

// File: rtl/sadc_tx.sv
// Acquisition wait, ready strobe and result shifter.
module sadc_tx #(
    parameter int RES_W     = 12,
    parameter int ACQ_FALLS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n_s,
    input  logic             fall,
    input  logic             start,
    input  logic [RES_W-1:0] result,
    output logic             dout,
    output logic             strobe
);
    import sadc_pkg::*;

    localparam int FC_W = $clog2(ACQ_FALLS + 1);
    localparam int BC_W = $clog2(RES_W + 1);

    tx_st_e           st;
    logic [FC_W-1:0]  fcnt;
    logic [BC_W-1:0]  bcnt;
    logic [RES_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= TX_IDLE;
            fcnt   <= '0;
            bcnt   <= '0;
            shreg  <= '0;
            dout   <= 1'b0;
            strobe <= 1'b0;
        end else if (cs_n_s) begin
            st     <= TX_IDLE;
            dout   <= 1'b0;
            strobe <= 1'b0;
        end else if (start) begin
            st     <= TX_WAIT;
            fcnt   <= '0;
            dout   <= 1'b0;
            strobe <= 1'b0;
        end else if (fall) begin
            case (st)
                TX_WAIT: begin
                    if (fcnt == FC_W'(ACQ_FALLS - 1)) begin
                        strobe <= 1'b1;
                        shreg  <= result;
                        bcnt   <= '0;
                        st     <= TX_DATA;
                    end else begin
                        fcnt <= fcnt + 1'b1;
                    end
                end
                TX_DATA: begin
                    strobe <= 1'b0;
                    if (bcnt == BC_W'(RES_W)) begin
                        dout <= 1'b0;
                        st   <= TX_TAIL;
                    end else begin
                        dout  <= shreg[RES_W-1];
                        shreg <= {shreg[RES_W-2:0], 1'b0};
                        bcnt  <= bcnt + 1'b1;
                    end
                end
                default: dout <= 1'b0;
            endcase
        end
    end

    // R1: outputs move only after a falling edge (or a new command)
    a_r1_fall_only: assert property (@(posedge clk) disable iff (rst)
        (!fall && !cs_n_s && !start) |=> ($stable(dout) && $stable(strobe)));

    // R4: the strobe never outlasts one serial period
    a_r4_strobe_one_period: assert property (@(posedge clk) disable iff (rst)
        (strobe && fall && !cs_n_s) |=> !strobe);

    // R5: no data bit is driven while the strobe is high
    a_r5_strobe_quiet: assert property (@(posedge clk) disable iff (rst)
        strobe |-> !dout);

    // R7: chip select high clears both outputs
    a_r7_abort_clears: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> (!dout && !strobe));

endmodule

// File: rtl/serial_adc_slave.sv
module serial_adc_slave
    import sadc_pkg::*;
#(
    parameter int RES_W       = 12,
    parameter int ACQ_FALLS   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    input  logic [RES_W-1:0] result,
    output logic             dout,
    output logic             dout_oe,
    output logic             strobe,
    output logic             ctl_valid,
    output logic [2:0]       ctl_chan,
    output logic             ctl_unipolar,
    output logic             ctl_single,
    output logic [1:0]       ctl_pmode
);
    logic cs_n_s, din_s, rise, fall;
    ctl_t ctl;

    sadc_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
        .cs_n_s(cs_n_s), .din_s(din_s), .rise(rise), .fall(fall)
    );

    sadc_cmd u_cmd (
        .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .rise(rise), .din_s(din_s),
        .ctl_valid(ctl_valid), .ctl(ctl)
    );

    sadc_tx #(.RES_W(RES_W), .ACQ_FALLS(ACQ_FALLS)) u_tx (
        .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .fall(fall),
        .start(ctl_valid && (ctl.pmode == PM_EXT_CLK)),
        .result(result), .dout(dout), .strobe(strobe)
    );

    always_ff @(posedge clk) begin
        if (rst) dout_oe <= 1'b0;
        else     dout_oe <= ~cs_n_s;
    end

    assign ctl_chan     = ctl.chan;
    assign ctl_unipolar = ctl.unipolar;
    assign ctl_single   = ctl.single;
    assign ctl_pmode    = ctl.pmode;

    // R9: enable follows the synchronised select one cycle later
    a_r9_oe_tracks_cs: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> !dout_oe);

endmodule

// File: tb/tb_serial_adc_slave.sv
module tb_serial_adc_slave;
    localparam int HALF = 8;
    localparam int RW   = 12;

    logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
    logic [RW-1:0] result = '0;
    logic dout, dout_oe, strobe, ctl_valid, ctl_unipolar, ctl_single;
    logic [2:0] ctl_chan;
    logic [1:0] ctl_pmode;

    serial_adc_slave dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din), .result(result),
        .dout(dout), .dout_oe(dout_oe), .strobe(strobe), .ctl_valid(ctl_valid),
        .ctl_chan(ctl_chan), .ctl_unipolar(ctl_unipolar), .ctl_single(ctl_single),
        .ctl_pmode(ctl_pmode)
    );

    always #5 clk = ~clk;

    int n_run = 0, n_fail = 0, cv_cnt = 0, idx = 0;
    logic [6:0]  cv_last = '0;
    logic [63:0] s_d, s_s;
    bit unstable, oe_bad;

    always @(negedge clk) begin
        if (!rst && ctl_valid) begin
            cv_cnt  = cv_cnt + 1;
            cv_last = {ctl_chan, ctl_unipolar, ctl_single, ctl_pmode};
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clk_bit(input logic b);
        din = b;
        repeat (HALF) @(negedge clk);
        if (idx < 63) idx++;
        s_d[idx] = dout;
        s_s[idx] = strobe;
        if (!dout_oe) oe_bad = 1'b1;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        if (dout !== s_d[idx] || strobe !== s_s[idx]) unstable = 1'b1;
        sclk = 1'b0;
    endtask

    task automatic frame_start();
        cs_n = 1'b0; idx = 0; s_d = '0; s_s = '0; unstable = 1'b0; oe_bad = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic frame_end();
        din = 1'b0;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) clk_bit(b[i]);
    endtask

    // p = number of clocks before the control word's first bit
    function automatic logic [63:0] exp_strobe(input int p);
        return 64'd1 << (p + 10);
    endfunction

    function automatic logic [63:0] exp_dout(input int p, input logic [RW-1:0] r);
        logic [63:0] v = '0;
        for (int j = 0; j < RW; j++) v[p + 11 + j] = r[RW-1-j];
        return v;
    endfunction

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        int base;
        logic [7:0] b;
        logic [RW-1:0] r;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        // R7 R9: reset state
        chk("R7", "reset outputs", {60'd0, dout, strobe, dout_oe, ctl_valid}, 64'd0);

        // External-clock sweep: every channel, polarity, input mode, varied leading zeros
        for (int ch = 0; ch < 8; ch++) begin
            for (int f = 0; f < 4; f++) begin
                int L = (ch + f) % 4;
                b = {1'b1, 3'(ch), 2'(f), 2'b11};
                r = RW'((ch * 613 + f * 1181 + 'h5A5) & 'hFFF);
                result = r;
                base = cv_cnt;
                frame_start();
                for (int z = 0; z < L; z++) clk_bit(1'b0);
                send_byte(b);
                for (int k = 0; k < 16; k++) clk_bit(1'b0);
                chk("R3", "decode pulse count", 64'(cv_cnt - base), 64'd1);
                chk("R2", "captured fields", 64'(cv_last), 64'(b[6:0]));
                chk("R4", "strobe position", s_s, exp_strobe(L));
                chk("R5", "result bits", s_d, exp_dout(L, r));
                chk("R6", "tail low", s_d >> (L + 23), 64'd0);
                chk("R1", "stable in high phase", 64'(unstable), 64'd0);
                chk("R9", "oe during frame", 64'(oe_bad), 64'd0);
                frame_end();
                chk("R9", "oe after frame", 64'(dout_oe), 64'd0);
            end
        end

        // R8: other modes stay silent
        for (int pm = 0; pm < 3; pm++) begin
            b = {1'b1, 3'(pm + 3), 1'b0, 1'b1, 2'(pm)};
            result = 12'hFFF;
            base = cv_cnt;
            frame_start();
            clk_bit(1'b0);
            send_byte(b);
            for (int k = 0; k < 16; k++) clk_bit(1'b0);
            chk("R3", "non-ext decode count", 64'(cv_cnt - base), 64'd1);
            chk("R3", "non-ext fields", 64'(cv_last), 64'(b[6:0]));
            chk("R8", "no strobe", s_s, 64'd0);
            chk("R8", "no result", s_d, 64'd0);
            frame_end();
        end

        // R8: second word in the same frame after a non-ext word
        b = 8'b1_101_0_1_11;
        r = 12'hA3C;
        result = r;
        base = cv_cnt;
        frame_start();
        send_byte(8'b1_010_1_0_01);
        for (int z = 0; z < 3; z++) clk_bit(1'b0);
        send_byte(b);
        for (int k = 0; k < 16; k++) clk_bit(1'b0);
        chk("R8", "two words decoded", 64'(cv_cnt - base), 64'd2);
        chk("R8", "second word fields", 64'(cv_last), 64'(b[6:0]));
        chk("R8", "second word strobe", s_s, exp_strobe(11));
        chk("R8", "second word result", s_d, exp_dout(11, r));
        frame_end();

        // R7: abort during the result shift
        result = 12'hFFF;
        frame_start();
        send_byte(8'b1_000_1_1_11);
        for (int k = 0; k < 4; k++) clk_bit(1'b0);
        chk("R5", "shift underway before abort", 64'(dout), 64'd1);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
        chk("R7", "outputs after abort", {62'd0, dout, strobe}, 64'd0);

        // R7: abort mid-word, then a clean frame
        frame_start();
        clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1);
        frame_end();
        b = 8'b1_011_0_0_11;
        r = 12'h123;
        result = r;
        base = cv_cnt;
        frame_start();
        send_byte(b);
        for (int k = 0; k < 16; k++) clk_bit(1'b0);
        chk("R7", "partial word discarded", 64'(cv_cnt - base), 64'd1);
        chk("R7", "fresh word fields", 64'(cv_last), 64'(b[6:0]));
        chk("R7", "fresh word result", s_d, exp_dout(0, r));
        frame_end();

        finish_up();
    end
endmodule